// File: doc/BRIEF.md
# Pattern-Fill Bulk State Writer

This block fills whole pages of a state memory with a short bit pattern repeated end to end. It is meant for bulk allocate and release updates in a per-word state table, where each heap word carries two state bits. An update that covers one or more full pages can then finish without any per-word work by the controlling agent. The controller loads a first page number, a page count, a pattern of up to 64 bits and a pattern length. It then writes the start command and suspends until the interrupt.

The block never reads the memory. It sends a stream of 64-bit beats on a valid/ready write port. Each beat carries the pattern copied across the full beat width. The beat address starts at the first byte of the first page and rises by 8 bytes per accepted beat. One 4 KB page takes 512 beats. When the last beat is accepted, the block drops busy and raises a level interrupt. The interrupt stays high until software clears it. Deciding whether to use the block, and translating addresses, are left to the controller.

Back-pressure rules on the write port: a beat transfers on a rising edge where `wr_valid` and `wr_ready` are both high. While `wr_valid` is high and `wr_ready` is low, the address and data hold their values and `wr_valid` stays high. `wr_valid` drops only after the last beat has been accepted.

Top module: `pfdma_top`

## Requirements
- R1: After reset, `wr_valid` and `irq` are 0, and every register reads 0. This includes status, where bit 0 is busy and bit 1 is done.
- R2: Registers read back what was last written while idle. The register indices are 0 = first page number (28 bits), 1 = page count (16 bits), 2 = pattern bits 31:0, 3 = pattern bits 63:32, and 4 = length select (3 bits).
- R3: A write of index 5 with bit 0 set starts a transfer when the block is idle. `wr_valid` is high from the next cycle. The first address is page number × 4096.
- R4: A transfer moves exactly page count × 512 beats. Beat n carries address page × 4096 + 8·n.
- R5: Every beat carries the pattern copied across all 64 bits. The pattern is the low 2^(sel+1) bits of the pattern register, where sel is the length select. Select values 6 and 7 behave like 5, which uses all 64 bits.
- R6: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold steady on the next cycle.
- R7: On the edge that accepts the last beat, busy falls and `irq` rises. After that edge, status reads 2 (busy 0, done 1).
- R8: Writing index 6 with bit 1 set clears done and `irq`. Writing it with bit 1 clear has no effect.
- R9: While busy, writes to indices 0 to 5 are ignored. The running transfer keeps its beat count, addresses and data, and the registers keep their earlier values.
- R10: Starting with a page count of 0 sends no beats. In this case `irq` is high from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index, for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Memory accepts the beat |
| wr_addr | output | 40 | Byte address of the beat |
| wr_data | output | 64 | Replicated pattern data |
| irq | output | 1 | Level completion interrupt |

## Verification
Each result has a fixed due time, counted in clock edges from its cause:
- A register write takes effect at the rising edge that samples it. The bench therefore reads it back on a later cycle, since `reg_rdata` is combinational.
- After a start is accepted, `wr_valid` is due one edge later.
- A beat counts on the rising edge where `wr_valid` and `wr_ready` are both high.
- `irq` is due on the same edge that accepts the last beat.

The bench drives `wr_ready` at the falling edge and samples the port shortly after. Each sample then stands for the handshake of the coming rising edge. The bench compares the cycle stamp of the last handshake with the cycle in which `irq` is first seen, and requires a difference of exactly one.

// File: rtl/pfdma_pkg.sv
package pfdma_pkg;
  typedef enum logic [2:0] {
    RA_PAGE   = 3'd0,
    RA_COUNT  = 3'd1,
    RA_PAT_LO = 3'd2,
    RA_PAT_HI = 3'd3,
    RA_PLEN   = 3'd4,
    RA_CTRL   = 3'd5,
    RA_STATUS = 3'd6
  } reg_idx_e;

  localparam int unsigned CTRL_GO_BIT   = 0;
  localparam int unsigned STAT_BUSY_BIT = 0;
  localparam int unsigned STAT_DONE_BIT = 1;
endpackage

// File: rtl/pfdma_regs.sv
module pfdma_regs
  import pfdma_pkg::*;
#(
  parameter int unsigned REG_W  = 32,
  parameter int unsigned PAGE_W = 28,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned LSEL_W = 3,
  localparam int unsigned PAT_W = 2 * REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [2:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              busy_i,
  input  logic              done_set_i,
  output logic              start_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [PAT_W-1:0]  pat_o,
  output logic [LSEL_W-1:0] lsel_o,
  output logic              irq_o
);
  logic [PAGE_W-1:0] page_q;
  logic [CNT_W-1:0]  count_q;
  logic [REG_W-1:0]  pat_lo_q, pat_hi_q;
  logic [LSEL_W-1:0] lsel_q;
  logic              done_q;
  logic              cfg_we, done_clr;

  assign cfg_we   = reg_wr_en && !busy_i;
  assign start_o  = cfg_we && (reg_addr == RA_CTRL) && reg_wdata[CTRL_GO_BIT];
  assign done_clr = reg_wr_en && (reg_addr == RA_STATUS) && reg_wdata[STAT_DONE_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q   <= '0;
      count_q  <= '0;
      pat_lo_q <= '0;
      pat_hi_q <= '0;
      lsel_q   <= '0;
    end else if (cfg_we) begin
      case (reg_addr)
        RA_PAGE:   page_q   <= reg_wdata[PAGE_W-1:0];
        RA_COUNT:  count_q  <= reg_wdata[CNT_W-1:0];
        RA_PAT_LO: pat_lo_q <= reg_wdata;
        RA_PAT_HI: pat_hi_q <= reg_wdata;
        RA_PLEN:   lsel_q   <= reg_wdata[LSEL_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          done_q <= 1'b0;
    else if (done_set_i) done_q <= 1'b1;
    else if (done_clr)   done_q <= 1'b0;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_PAGE:   reg_rdata = REG_W'(page_q);
      RA_COUNT:  reg_rdata = REG_W'(count_q);
      RA_PAT_LO: reg_rdata = pat_lo_q;
      RA_PAT_HI: reg_rdata = pat_hi_q;
      RA_PLEN:   reg_rdata = REG_W'(lsel_q);
      RA_STATUS: begin
        reg_rdata[STAT_BUSY_BIT] = busy_i;
        reg_rdata[STAT_DONE_BIT] = done_q;
      end
      default:   reg_rdata = '0;
    endcase
  end

  assign page_o  = page_q;
  assign count_o = count_q;
  assign pat_o   = {pat_hi_q, pat_lo_q};
  assign lsel_o  = lsel_q;
  assign irq_o   = done_q;

  // R7
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_set_i |=> irq_o);

  // R8
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_clr && !done_set_i) |=> !irq_o);

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> ($stable(page_q) && $stable(count_q) && $stable(pat_o) && $stable(lsel_q)));
endmodule

// File: rtl/pfdma_pattern.sv
module pfdma_pattern #(
  parameter int unsigned PAT_W  = 64,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LSEL_W = 3,
  localparam int unsigned MAX_SEL = $clog2(PAT_W) - 1
) (
  input  logic [PAT_W-1:0]  pat_i,
  input  logic [LSEL_W-1:0] lsel_i,
  output logic [DATA_W-1:0] data_o
);
  logic [LSEL_W-1:0] sel_c;
  logic [PAT_W-1:0]  mask;

  always_comb begin
    sel_c = (32'(lsel_i) > MAX_SEL) ? LSEL_W'(MAX_SEL) : lsel_i;
    mask  = (PAT_W'(2) << sel_c) - PAT_W'(1);
  end

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_rep
      localparam int unsigned POS = gi % PAT_W;
      assign data_o[gi] = pat_i[PAT_W'(POS) & mask];
    end
  endgenerate
endmodule

// File: rtl/pfdma_seq.sv
module pfdma_seq #(
  parameter int unsigned ADDR_W  = 40,
  parameter int unsigned PG_SH   = 12,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned DATA_W  = 64,
  localparam int unsigned PAGE_W  = ADDR_W - PG_SH,
  localparam int unsigned BYTE_SH = $clog2(DATA_W / 8),
  localparam int unsigned BEAT_SH = PG_SH - BYTE_SH,
  localparam int unsigned LEFT_W  = CNT_W + BEAT_SH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              busy_o,
  output logic              done_set_o
);
  logic              busy_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEFT_W-1:0] left_q;
  logic              accept, last_beat;

  assign accept    = busy_q && wr_ready;
  assign last_beat = accept && (left_q == LEFT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      addr_q <= '0;
      left_q <= '0;
    end else if (start_i && !busy_q) begin
      addr_q <= {page_i, {PG_SH{1'b0}}};
      left_q <= LEFT_W'(count_i) << BEAT_SH;
      busy_q <= (count_i != '0);
    end else if (accept) begin
      addr_q <= addr_q + ADDR_W'(DATA_W / 8);
      left_q <= left_q - LEFT_W'(1);
      if (left_q == LEFT_W'(1)) busy_q <= 1'b0;
    end
  end

  assign wr_valid   = busy_q;
  assign wr_addr    = addr_q;
  assign busy_o     = busy_q;
  assign done_set_o = last_beat || (start_i && !busy_q && count_i == '0);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr)));

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !last_beat) |=> (wr_valid && wr_addr == $past(wr_addr) + ADDR_W'(DATA_W / 8)));
endmodule

// File: rtl/pfdma_top.sv
module pfdma_top #(
  parameter int unsigned ADDR_W = 40,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned REG_W  = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PG_SH  = 12,
  localparam int unsigned PAGE_W = ADDR_W - PG_SH,
  localparam int unsigned PAT_W  = 2 * REG_W,
  localparam int unsigned LSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [2:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              irq
);
  logic              busy, done_set, start;
  logic [PAGE_W-1:0] page;
  logic [CNT_W-1:0]  count;
  logic [PAT_W-1:0]  pat;
  logic [LSEL_W-1:0] lsel;

  pfdma_regs #(.REG_W(REG_W), .PAGE_W(PAGE_W), .CNT_W(CNT_W), .LSEL_W(LSEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy_i(busy),
    .done_set_i(done_set), .start_o(start), .page_o(page), .count_o(count),
    .pat_o(pat), .lsel_o(lsel), .irq_o(irq)
  );

  pfdma_pattern #(.PAT_W(PAT_W), .DATA_W(DATA_W), .LSEL_W(LSEL_W)) u_pat (
    .pat_i(pat), .lsel_i(lsel), .data_o(wr_data)
  );

  pfdma_seq #(.ADDR_W(ADDR_W), .PG_SH(PG_SH), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .page_i(page), .count_i(count),
    .wr_ready(wr_ready), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .busy_o(busy), .done_set_o(done_set)
  );

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> $stable(wr_data));

  // R7
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_valid) |-> irq);
endmodule

// File: tb/tb_pfdma_top.sv
module tb_pfdma_top;
  logic        clk = 0, rst_n = 0;
  logic        reg_wr_en = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        wr_valid, wr_ready = 0, irq;
  logic [39:0] wr_addr;
  logic [63:0] wr_data;

  pfdma_top dut (.clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq));

  always #2 clk = ~clk;

  int nchk = 0, nerr = 0, cyc = 0;
  int nbeats = 0, addr_err = 0, data_err = 0, hold_err = 0, last_hs = 0;
  bit stall = 0, hold_pend = 0;
  logic [39:0] exp_base = 0, hold_addr = 0;
  logic [63:0] exp_data = 0, hold_data = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    wr_ready = stall ? (cyc % 3 != 0) : 1'b1;
    #1;
    if (hold_pend && !(wr_valid && wr_addr == hold_addr && wr_data == hold_data)) hold_err++;
    if (wr_valid && wr_ready) begin
      if (wr_addr !== exp_base + 40'(nbeats) * 8) addr_err++;
      if (wr_data !== exp_data) data_err++;
      nbeats++;
      last_hs = cyc;
    end
    hold_pend = wr_valid && !wr_ready;
    hold_addr = wr_addr;
    hold_data = wr_data;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr_en = 0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #2; v = reg_rdata;
  endtask

  function automatic logic [63:0] rep(input logic [63:0] p, input int sel);
    int len;
    logic [63:0] r;
    len = 2 << ((sel > 5) ? 5 : sel);
    for (int k = 0; k < 64; k++) r[k] = p[k % len];
    return r;
  endfunction

  task automatic wait_irq(input int limit, output int at);
    at = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk); #2;
      if (irq) begin at = cyc; break; end
    end
  endtask

  task automatic run(input int page, input int cnt, input int sel, input logic [63:0] p, input bit st);
    int at;
    logic [31:0] v;
    stall = st;
    wreg(0, 32'(page)); wreg(1, 32'(cnt));
    wreg(2, p[31:0]); wreg(3, p[63:32]); wreg(4, 32'(sel));
    exp_base = 40'(page) * 4096;
    exp_data = rep(p, sel);
    nbeats = 0; addr_err = 0; data_err = 0; hold_err = 0;
    wreg(5, 1);
    #2;
    chk(wr_valid == (cnt != 0), "R3 valid after start", 64'(wr_valid), 64'(cnt != 0));
    if (cnt == 0) chk(irq == 1 && !wr_valid, "R10 zero count irq", 64'(irq), 1);
    wait_irq(cnt * 512 * 3 + 20, at);
    chk(nbeats == cnt * 512, "R4 beat count", 64'(nbeats), 64'(cnt * 512));
    chk(addr_err == 0, "R3 R4 beat addresses", 64'(addr_err), 0);
    chk(data_err == 0, "R5 replicated data", 64'(data_err), 0);
    chk(hold_err == 0, "R6 hold under stall", 64'(hold_err), 0);
    if (cnt != 0) chk(at == last_hs + 1, "R7 irq timing", 64'(at), 64'(last_hs + 1));
    rreg(6, v);
    chk(v == 2, "R7 status after done", 64'(v), 2);
    wreg(6, 0);
    chk(irq == 1, "R8 write without clear bit", 64'(irq), 1);
    wreg(6, 2);
    chk(irq == 0, "R8 clear irq", 64'(irq), 0);
    stall = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int at;
    repeat (3) @(negedge clk);
    #1;
    chk(!wr_valid && !irq, "R1 outputs in reset", 64'({wr_valid, irq}), 0);
    rst_n = 1;
    for (int a = 0; a < 7; a++) begin
      rreg(3'(a), v);
      chk(v == 0, "R1 register reset", 64'(v), 0);
    end
    wreg(0, 32'hFFFF_FFFF); rreg(0, v);
    chk(v == 32'h0FFF_FFFF, "R2 page readback", 64'(v), 64'h0FFF_FFFF);
    wreg(1, 32'h0001_2345); rreg(1, v);
    chk(v == 32'h2345, "R2 count readback", 64'(v), 64'h2345);
    wreg(2, 32'hA5A5_0F0F); rreg(2, v);
    chk(v == 32'hA5A5_0F0F, "R2 pattern low readback", 64'(v), 64'hA5A5_0F0F);
    wreg(3, 32'h1234_5678); rreg(3, v);
    chk(v == 32'h1234_5678, "R2 pattern high readback", 64'(v), 64'h1234_5678);
    wreg(4, 32'hF); rreg(4, v);
    chk(v == 7, "R2 length select readback", 64'(v), 7);

    for (int sel = 0; sel < 8; sel++)
      for (int cnt = 1; cnt <= 2; cnt++)
        for (int st = 0; st < 2; st++)
          run(3 + sel * 5 + cnt, cnt, sel, 64'hC3A5_9612_7E01_B4D9 ^ 64'(sel * 7919), st[0]);
    run(9, 0, 2, 64'h6, 0);
    run(1000, 3, 0, 64'h1, 1);

    // R9 writes while busy are ignored
    stall = 0;
    wreg(0, 20); wreg(1, 1); wreg(2, 32'h0000_0009); wreg(3, 0); wreg(4, 1);
    exp_base = 40'(20) * 4096; exp_data = rep(64'h9, 1);
    nbeats = 0; addr_err = 0; data_err = 0;
    wreg(5, 1);
    repeat (50) @(negedge clk);
    wreg(0, 77); wreg(1, 5); wreg(2, 32'hFFFF_FFFF); wreg(4, 0); wreg(5, 1);
    wait_irq(2000, at);
    chk(nbeats == 512, "R9 beat count kept", 64'(nbeats), 512);
    chk(addr_err == 0 && data_err == 0, "R9 stream kept", 64'(addr_err + data_err), 0);
    rreg(0, v); chk(v == 20, "R9 page kept", 64'(v), 20);
    rreg(2, v); chk(v == 9, "R9 pattern kept", 64'(v), 9);
    rreg(1, v); chk(v == 1, "R9 count kept", 64'(v), 1);
    repeat (5) @(negedge clk);
    chk(!wr_valid, "R9 ignored start", 64'(wr_valid), 0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule